// File: doc/BRIEF.md
# Pixel Byte Zero-Suppression Encoder

This block compacts binary pixel-hit readout in which each bit stands for one pixel and the bits arrive in 16-bit words. Each event is framed as a run of header words, a run of chip-status words, a fixed-length payload and a run of trailer words. The framing words leave the block unchanged. The payload is cut into bytes, and only the bytes that hold at least one hit are forwarded. Each forwarded byte goes out in a 16-bit word together with its 6-bit position inside the 64-byte block it belongs to.

At the first payload word of every 64-byte block, the encoder emits a block word that carries the block number. A decoder can rebuild absolute pixel addresses from the block word and the labels that follow it. Both sides use a valid/ready handshake. A single input word can expand into as many as three output words, so the input is throttled whenever the output is stalled or a word is still being expanded.

Top module: `pzs_encoder`

## Requirements
- R1: A payload byte equal to 0x00 produces no output word.
- R2: A nonzero payload byte is emitted as {2'b00, label[5:0], byte[7:0]}. The label is the byte's offset inside its 64-byte block. For payload word k (counted from 0 within the event), the bits [15:8] get label 2*(k mod 32) and the bits [7:0] get label 2*(k mod 32)+1.
- R3: When k mod 32 = 0, a block word {2'b10, block_number[13:0]} is emitted before any data word of that block, with block_number = k / 32.
- R4: The block word is still emitted when every byte of its block is zero.
- R5: The first HDR_WORDS + STAT_WORDS words and the last TRL_WORDS words of each event are forwarded unchanged, one output word each, zero values included.
- R6: Events follow back to back with no separator. Payload counting and block numbering restart at 0 in every event.
- R7: Within one input word, the word for bits [15:8] leaves before the word for bits [7:0]. Output order matches input order.
- R8: While out_valid_o is high and out_ready_i is low, out_data_o holds steady. No word is lost or duplicated under any pattern of stalls on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word is valid |
| in_ready_o | output | 1 | Encoder accepts the input word |
| in_data_i | input | 16 | Input word (header, status, payload or trailer) |
| out_valid_o | output | 1 | Output word is valid |
| out_ready_i | input | 1 | Downstream accepts the output word |
| out_data_o | output | 16 | Encoded or passed-through word |

## Verification
Two things can happen in the same cycle. The last pending output of one word can leave while the next input word is being accepted, and that next word may open a new block, so it must queue a block word behind the outgoing byte. The bench runs payload patterns with both bytes, one byte or no byte set, under an output that is always ready, and also under random output and input throttling. This puts accept and final emission in the same cycle, both at block starts and between blocks. The output stream is compared word by word, in order, against a queue that the bench computes from the event position of each word, and every stalled cycle is checked for a held output.

// File: rtl/pzs_pkg.sv
package pzs_pkg;
  localparam int WORD_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int LABEL_W   = 6;
  localparam int FLAG_W    = WORD_W - LABEL_W - BYTE_W;
  localparam int IDX_W     = WORD_W - FLAG_W;
  localparam int BLK_BYTES = 1 << LABEL_W;
  localparam int BLK_WORDS = BLK_BYTES / 2;

  localparam logic [FLAG_W-1:0] FLAG_DATA  = 2'b00;
  localparam logic [FLAG_W-1:0] FLAG_BLOCK = 2'b10;

  // pending-source slots, lower index = higher priority
  localparam int NSRC  = 4;
  localparam int S_RAW = 0;
  localparam int S_BLK = 1;
  localparam int S_HI  = 2;
  localparam int S_LO  = 3;

  typedef enum logic [1:0] {PH_HDR, PH_STAT, PH_PAY, PH_TRL} phase_e;
endpackage

// File: rtl/pzs_phase_track.sv
module pzs_phase_track
  import pzs_pkg::*;
#(
  parameter int HDR_WORDS  = 5,
  parameter int STAT_WORDS = 4,
  parameter int PAY_WORDS  = 4096,
  parameter int TRL_WORDS  = 5,
  localparam int MAXN = (PAY_WORDS > HDR_WORDS + STAT_WORDS + TRL_WORDS) ?
                        PAY_WORDS : HDR_WORDS + STAT_WORDS + TRL_WORDS,
  localparam int CW   = $clog2(MAXN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output phase_e        phase_o,
  output logic [CW-1:0] idx_o
);
  phase_e        phase_q, phase_n;
  logic [CW-1:0] idx_q;
  logic [CW-1:0] last;

  always_comb begin
    unique case (phase_q)
      PH_HDR:  begin last = CW'(HDR_WORDS - 1);  phase_n = PH_STAT; end
      PH_STAT: begin last = CW'(STAT_WORDS - 1); phase_n = PH_PAY;  end
      PH_PAY:  begin last = CW'(PAY_WORDS - 1);  phase_n = PH_TRL;  end
      default: begin last = CW'(TRL_WORDS - 1);  phase_n = PH_HDR;  end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HDR;
      idx_q   <= '0;
    end else if (adv_i) begin
      if (idx_q == last) begin
        phase_q <= phase_n;
        idx_q   <= '0;
      end else begin
        idx_q   <= idx_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;

  AST_EVENT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && phase_q == PH_TRL && idx_q == CW'(TRL_WORDS - 1)
    |=> phase_q == PH_HDR && idx_q == '0); // R6
  AST_PAY_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && phase_q == PH_STAT && idx_q == CW'(STAT_WORDS - 1)
    |=> phase_q == PH_PAY && idx_q == '0); // R5
endmodule

// File: rtl/pzs_expander.sv
module pzs_expander
  import pzs_pkg::*;
#(
  parameter int CW = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              is_pay_i,
  input  logic [CW-1:0]     pay_idx_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o
);
  localparam int OFF_W = LABEL_W - 1;

  logic [NSRC-1:0]   pend_q, pend_new, sel, left;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  blk_q;
  logic [OFF_W-1:0]  off_q;
  logic [31:0]       pidx;
  logic [OFF_W-1:0]  off_in;
  logic [IDX_W-1:0]  blk_in;
  logic              fire, take;

  assign pidx   = 32'(pay_idx_i);
  assign off_in = OFF_W'(pidx % BLK_WORDS);
  assign blk_in = IDX_W'(pidx / BLK_WORDS);

  always_comb begin
    pend_new        = '0;
    pend_new[S_RAW] = !is_pay_i;
    pend_new[S_BLK] = is_pay_i && off_in == '0;
    pend_new[S_HI]  = is_pay_i && in_data_i[WORD_W-1:BYTE_W] != '0;
    pend_new[S_LO]  = is_pay_i && in_data_i[BYTE_W-1:0] != '0;
  end

  // lowest set slot wins
  assign sel         = pend_q & (~pend_q + 1'b1);
  assign out_valid_o = |pend_q;
  assign fire        = out_valid_o && out_ready_i;
  assign left        = fire ? (pend_q & ~sel) : pend_q;
  assign in_ready_o  = left == '0;
  assign take        = in_valid_i && in_ready_o;

  always_comb begin
    out_data_o = word_q;
    if (sel[S_BLK])     out_data_o = {FLAG_BLOCK, blk_q};
    else if (sel[S_HI]) out_data_o = {FLAG_DATA, off_q, 1'b0, word_q[WORD_W-1:BYTE_W]};
    else if (sel[S_LO]) out_data_o = {FLAG_DATA, off_q, 1'b1, word_q[BYTE_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      word_q <= '0;
      blk_q  <= '0;
      off_q  <= '0;
    end else if (take) begin
      pend_q <= pend_new;
      word_q <= in_data_i;
      blk_q  <= blk_in;
      off_q  <= off_in;
    end else begin
      pend_q <= left;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R8
  AST_IDLE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o); // R8
  AST_RAW_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[S_RAW] |-> $countones(pend_q) == 1); // R5
  AST_BYTE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (sel[S_HI] || sel[S_LO]) |-> out_data_o[BYTE_W-1:0] != '0); // R1
  AST_HI_BEFORE_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && sel[S_HI] && pend_q[S_LO] |=> out_valid_o && out_data_o[BYTE_W] == 1'b1); // R7
endmodule

// File: rtl/pzs_encoder.sv
module pzs_encoder
  import pzs_pkg::*;
#(
  parameter int HDR_WORDS  = 5,
  parameter int STAT_WORDS = 4,
  parameter int PAY_WORDS  = 4096,
  parameter int TRL_WORDS  = 5,
  localparam int MAXN = (PAY_WORDS > HDR_WORDS + STAT_WORDS + TRL_WORDS) ?
                        PAY_WORDS : HDR_WORDS + STAT_WORDS + TRL_WORDS,
  localparam int CW   = $clog2(MAXN + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [15:0] in_data_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [15:0] out_data_o
);
  phase_e        phase;
  logic [CW-1:0] idx;
  logic          adv;

  assign adv = in_valid_i && in_ready_o;

  pzs_phase_track #(
    .HDR_WORDS (HDR_WORDS),
    .STAT_WORDS(STAT_WORDS),
    .PAY_WORDS (PAY_WORDS),
    .TRL_WORDS (TRL_WORDS)
  ) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .phase_o(phase),
    .idx_o  (idx)
  );

  pzs_expander #(.CW(CW)) u_expand (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  (in_data_i),
    .is_pay_i   (phase == PH_PAY),
    .pay_idx_i  (idx),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (out_data_o)
  );
endmodule

// File: tb/pzs_encoder_test.sv
module pzs_encoder_test;
  localparam int HDR = 5, STAT = 4, PAY = 80, TRL = 5;
  localparam int TOTAL = HDR + STAT + PAY + TRL;
  localparam int NEV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;

  always #2 clk = ~clk;

  pzs_encoder #(.HDR_WORDS(HDR), .STAT_WORDS(STAT), .PAY_WORDS(PAY), .TRL_WORDS(TRL)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  int compared = 0, mismatched = 0;
  logic [15:0] q_data [0:4095];
  int          q_kind [0:4095];
  int head = 0, tail = 0;
  bit done = 0;

  function automatic logic [15:0] gen_word(int ev, int pos);
    int p;
    logic [31:0] v;
    if (pos < HDR + STAT || pos >= HDR + STAT + PAY)
      return (ev == 0 && pos == 0) ? 16'h0 : 16'(ev * 16'h1111 ^ pos * 16'h0203);
    p = pos - HDR - STAT;
    case (ev)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h0001 << (p % 16);
      3: case (p % 4) 0: return 16'h0000; 1: return 16'h00A5; 2: return 16'h5A00; default: return 16'h8001; endcase
      4: return (p == 31) ? 16'h00FF : (p == 32) ? 16'h0100 : 16'h0000;
      default: begin
        v = 32'(p) * 32'h9E37 + 32'(ev) * 977;
        return ((p + ev) % 3 == 0) ? v[15:0] : (((p + ev) % 3 == 1) ? (v[15:0] & 16'h00F0) : 16'h0000);
      end
    endcase
  endfunction

  task automatic push(logic [15:0] d, int k);
    q_data[tail % 4096] = d;
    q_kind[tail % 4096] = k;
    tail++;
  endtask

  task automatic push_exp(logic [15:0] w, int pos);
    int p;
    if (pos < HDR + STAT || pos >= HDR + STAT + PAY) begin
      push(w, 0);
    end else begin
      p = pos - HDR - STAT;
      if (p % 32 == 0) push({2'b10, 14'(p / 32)}, 1);
      if (w[15:8] != 0) push({2'b00, 6'((p % 32) * 2), w[15:8]}, 2);
      if (w[7:0] != 0) push({2'b00, 6'((p % 32) * 2 + 1), w[7:0]}, 3);
    end
  endtask

  function automatic string tag(int k);
    case (k)
      0: return "R5 pass-through";
      1: return "R3 R4 R6 block word";
      2: return "R2 R1 high byte";
      default: return "R2 R7 low byte";
    endcase
  endfunction

  logic        prev_stall = 1'b0;
  logic [15:0] prev_data = '0;
  bit          accepted = 0;

  task automatic step(int ev, int mode, inout int pos);
    @(negedge clk);
    if (accepted) begin in_valid = 1'b0; accepted = 0; end
    case (mode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom % 2) == 0;
      default: out_ready = ($urandom % 4) == 0;
    endcase
    if (!in_valid && pos < TOTAL && (ev % 2 == 0 || ($urandom % 3) != 0)) begin
      in_valid = 1'b1;
      in_data  = gen_word(ev, pos);
    end
    #1;
    if (prev_stall) begin
      compared++;
      if (!out_valid || out_data != prev_data) begin
        mismatched++;
        $display("FAIL R8 hold: got valid=%0b data=%h expected valid=1 data=%h", out_valid, out_data, prev_data);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    if (out_valid && out_ready) begin
      compared++;
      if (head == tail) begin
        mismatched++;
        $display("FAIL R1 R8 extra word: got %h expected none", out_data);
      end else begin
        if (out_data != q_data[head % 4096]) begin
          mismatched++;
          $display("FAIL %s: got %h expected %h", tag(q_kind[head % 4096]), out_data, q_data[head % 4096]);
        end
        head++;
      end
    end
    if (in_valid && in_ready) begin
      push_exp(in_data, pos);
      pos++;
      accepted = 1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      mismatched++;
      $display("FAIL R8 reset: got valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    for (int ev = 0; ev < NEV; ev++) begin
      int pos = 0;
      while (pos < TOTAL) step(ev, ev % 3, pos);
    end
    begin
      int guard = 0;
      int pos = TOTAL;
      while (head != tail && guard < 2000) begin step(0, 0, pos); guard++; end
      for (int i = 0; i < 4; i++) step(0, 0, pos);
    end
    compared++;
    if (head != tail) begin
      mismatched++;
      $display("FAIL R1 R8 drain: got %0d words left expected 0", tail - head);
    end
    compared++;
    if (out_valid !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 idle: got valid=%b expected 0", out_valid);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule